// File: doc/BRIEF.md
# Block-Copy DMA Engine

This engine moves a contiguous block of words from one memory region to another without processor involvement. Software programs a source address, a destination address and a word count through a small register port. It then sets the start bit in the control/status register. From then on the engine acts as a memory master and copies the block one word at a time.

Each word takes two transactions on a single-word request/response memory port: a read that waits for returned data, then a write that waits for an acknowledge. When the final write is acknowledged, the engine sets a sticky completion flag. Software can route that flag to an interrupt line and clears it by writing a 1 to it.

Top module: `dma_block_copy`

## Requirements
- R1: After reset, all four registers read 0, `irq` is low and `mem_req` is low.
- R2: Register offsets on `cfg_addr`: 0x0 is control/status (bit0 busy/start, bit1 done, bit2 interrupt enable), 0x4 is source address, 0x8 is destination address, 0xC is length in words. Operand registers read back the value last written while idle.
- R3: Writing control/status with bit0=1 while idle and with a nonzero length starts a copy on the next cycle. Bit0 then reads 1 until the cycle after the final write acknowledge.
- R4: Each word is handled in this order. A read request (`mem_req`=1, `mem_we`=0, `mem_addr`=current source) is held until `mem_rvalid`. Next comes a write request (`mem_we`=1, `mem_addr`=current destination) that is held until `mem_wack`. Both addresses then advance by 4 for the next word.
- R5: The data written to each destination word equals the data returned by the read of the matching source word, so the destination block ends up equal to the source block.
- R6: Starting with a length of 0 sets done on the next cycle and issues no memory request.
- R7: `irq` equals done AND interrupt-enable at every cycle. Bit2 of a control/status write sets the enable at any time.
- R8: Writing control/status with bit1=1 clears done, unless done is being set in the same cycle. Writing bit1=0 leaves done unchanged.
- R9: Writes to the source, destination or length register while busy are ignored. Readback and the running copy are both unaffected.
- R10: A start write while busy has no effect on the running copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_rvalid | input | 1 | Read data valid |
| mem_wack | input | 1 | Write acknowledge |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong phase or counter inside the engine appears on the memory port within one cycle. The symptoms are a request that drops before its response, a write issued without a preceding read, or an address that fails to step by 4. These are compared on every clock against a behavioural model. A corrupted word count or capture register is visible only at the end, as a wrong destination word or a busy bit that clears early or late. A stuck done or enable bit shows on `irq` in the cycle after the offending register write.

// File: rtl/dma_block_copy.sv
module dma_block_copy #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [3:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rvalid,
  input  logic          mem_wack,
  output logic          irq
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  typedef enum logic [1:0] {IDLE, RD, WR} phase_t;

  phase_t        ph;
  logic [AW-1:0] src_q, dst_q, cur_src, cur_dst;
  logic [LW-1:0] len_q, left_q;
  logic [DW-1:0] buf_q;
  logic          done_q, ie_q;

  logic busy, csr_wr, go, last, fin;
  assign busy   = ph != IDLE;
  assign csr_wr = cfg_wr && cfg_addr[3:2] == 2'd0;
  assign go     = csr_wr && cfg_wdata[0] && !busy;
  assign last   = left_q == LW'(1);
  assign fin    = (go && len_q == '0) || (ph == WR && mem_wack && last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      len_q   <= '0;
      cur_src <= '0;
      cur_dst <= '0;
      left_q  <= '0;
      buf_q   <= '0;
      done_q  <= 1'b0;
      ie_q    <= 1'b0;
    end else begin
      if (cfg_wr && !busy) begin
        case (cfg_addr[3:2])
          2'd1: src_q <= cfg_wdata[AW-1:0];
          2'd2: dst_q <= cfg_wdata[AW-1:0];
          2'd3: len_q <= cfg_wdata[LW-1:0];
          default: ;
        endcase
      end
      if (csr_wr) ie_q <= cfg_wdata[2];
      if (fin) done_q <= 1'b1;
      else if (csr_wr && cfg_wdata[1]) done_q <= 1'b0;
      case (ph)
        IDLE: if (go && len_q != '0) begin
          cur_src <= src_q;
          cur_dst <= dst_q;
          left_q  <= len_q;
          ph      <= RD;
        end
        RD: if (mem_rvalid) begin
          buf_q <= mem_rdata;
          ph    <= WR;
        end
        WR: if (mem_wack) begin
          if (last) ph <= IDLE;
          else begin
            cur_src <= cur_src + STEP;
            cur_dst <= cur_dst + STEP;
            left_q  <= left_q - LW'(1);
            ph      <= RD;
          end
        end
        default: ph <= IDLE;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr[3:2])
      2'd0: cfg_rdata[2:0] = {ie_q, done_q, busy};
      2'd1: cfg_rdata[AW-1:0] = src_q;
      2'd2: cfg_rdata[AW-1:0] = dst_q;
      default: cfg_rdata[LW-1:0] = len_q;
    endcase
  end

  assign mem_req   = busy;
  assign mem_we    = ph == WR;
  assign mem_addr  = (ph == WR) ? cur_dst : cur_src;
  assign mem_wdata = buf_q;
  assign irq       = done_q && ie_q;
endmodule

module dma_block_copy_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] mem_rdata,
  input logic          mem_rvalid,
  input logic          mem_wack
);
  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && !mem_rvalid |=> mem_req && !mem_we && $stable(mem_addr));
  // R4
  wr_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_rvalid |=> mem_req && mem_we);
  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_wack |=> mem_req && mem_we && $stable(mem_addr) && $stable(mem_wdata));
  // R5
  wdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_rvalid |=> mem_wdata == $past(mem_rdata));
  // R4
  after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_wack |=> !mem_we);
endmodule

bind dma_block_copy dma_block_copy_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
  .mem_rvalid(mem_rvalid), .mem_wack(mem_wack)
);

// File: tb/test_dma_block_copy.sv
module test_dma_block_copy;
  logic        clk = 0, rst_n = 0;
  logic        cfg_wr = 0;
  logic [3:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic        mem_req, mem_we, irq;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 0;
  logic        mem_rvalid = 0, mem_wack = 0;

  dma_block_copy i_dma_block_copy (.*);

  always #2 clk = ~clk;

  int tests = 0, fails = 0, lat = 1, wcnt = 0, cycles = 0;
  logic [31:0] mem [256];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder
  always @(negedge clk) begin
    mem_rvalid <= 0;
    mem_wack   <= 0;
    if (rst_n && mem_req && !mem_rvalid && !mem_wack) begin
      if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0;
        if (mem_we) begin
          mem[mem_addr[9:2]] = mem_wdata;
          mem_wack <= 1;
        end else begin
          mem_rdata  <= mem[mem_addr[9:2]];
          mem_rvalid <= 1;
        end
      end
    end else if (!mem_req) wcnt = 0;
  end

  // behavioural reference model
  int m_ph, m_left, m_len;
  logic [31:0] m_src, m_dst, m_cs, m_cd;
  bit m_done, m_ie;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_len = 0; m_src = 0; m_dst = 0;
      m_cs = 0; m_cd = 0; m_done = 0; m_ie = 0;
    end else begin
      automatic bit csrw = cfg_wr && cfg_addr[3:2] == 0;
      automatic bit go = csrw && cfg_wdata[0] && m_ph == 0;
      automatic bit fin = (go && m_len == 0) || (m_ph == 2 && mem_wack && m_left == 1);
      automatic int old_len = m_len;
      automatic int ph0 = m_ph;
      if (cfg_wr && ph0 == 0) begin
        if (cfg_addr[3:2] == 1) m_src = cfg_wdata;
        if (cfg_addr[3:2] == 2) m_dst = cfg_wdata;
        if (cfg_addr[3:2] == 3) m_len = cfg_wdata[15:0];
      end
      if (csrw) m_ie = cfg_wdata[2];
      if (fin) m_done = 1;
      else if (csrw && cfg_wdata[1]) m_done = 0;
      if (ph0 == 0 && go && old_len != 0) begin
        m_ph = 1; m_left = old_len;
        m_cs = (cfg_wr && cfg_addr[3:2] == 1) ? m_cs : m_src;
        m_cd = m_dst;
      end else if (ph0 == 1 && mem_rvalid) m_ph = 2;
      else if (ph0 == 2 && mem_wack) begin
        if (m_left == 1) m_ph = 0;
        else begin m_ph = 1; m_left--; m_cs += 4; m_cd += 4; end
      end
    end
  end

  // per-clock comparison
  always @(posedge clk) begin
    cycles++;
    #1;
    if (rst_n) begin
      chk("R3 mem_req", {31'b0, mem_req}, {31'b0, m_ph != 0});
      chk("R4 mem_we", {31'b0, mem_we}, {31'b0, m_ph == 2});
      if (m_ph != 0) chk("R4 mem_addr", mem_addr, m_ph == 2 ? m_cd : m_cs);
      if (m_ph == 2) chk("R5 mem_wdata", mem_wdata, mem[m_cs[9:2]]);
      chk("R7 irq", {31'b0, irq}, {31'b0, m_done && m_ie});
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [31:0] exp);
    cfg_addr = a;
    #0.5;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic wait_idle();
    cfg_addr = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!cfg_rdata[0]) break;
    end
  endtask

  task automatic copy(logic [31:0] s, logic [31:0] d, int n, int l);
    lat = l;
    wr(4'h4, s); wr(4'h8, d); wr(4'hC, n);
    wr(4'h0, 32'h5);
    wait_idle();
    for (int i = 0; i < n; i++)
      chk("R5 dest word", mem[d[9:2] + i], mem[s[9:2] + i]);
    rd("R3 done after copy", 4'h0, 32'h6);
    wr(4'h0, 32'h6);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA5A50000 ^ (i * 32'h01030507);
    repeat (3) @(negedge clk);
    rd("R1 csr", 4'h0, 0); rd("R1 src", 4'h4, 0);
    rd("R1 dst", 4'h8, 0); rd("R1 len", 4'hC, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rst_n = 1;
    @(negedge clk);
    // R2 readback
    wr(4'h4, 32'h100); wr(4'h8, 32'h200); wr(4'hC, 4);
    rd("R2 src", 4'h4, 32'h100); rd("R2 dst", 4'h8, 32'h200); rd("R2 len", 4'hC, 4);
    // R3 start, R9/R10 while busy
    wr(4'h0, 32'h5);
    rd("R3 busy", 4'h0, 32'h5);
    wr(4'h4, 32'h300); wr(4'hC, 9);
    rd("R9 src held", 4'h4, 32'h100); rd("R9 len held", 4'hC, 4);
    wr(4'h0, 32'h5);
    rd("R10 still busy", 4'h0, 32'h5);
    wait_idle();
    for (int i = 0; i < 4; i++) chk("R5 dest word", mem[(32'h200 >> 2) + i], mem[(32'h100 >> 2) + i]);
    chk("R9 no overrun", mem[(32'h200 >> 2) + 4], 32'hA5A50000 ^ (((32'h200 >> 2) + 4) * 32'h01030507));
    rd("R7 csr done ie", 4'h0, 32'h6);
    chk("R7 irq high", {31'b0, irq}, 1);
    // R8: bit1=0 keeps, bit1=1 clears
    wr(4'h0, 32'h0);
    rd("R8 done kept", 4'h0, 32'h2);
    chk("R7 irq masked", {31'b0, irq}, 0);
    wr(4'h0, 32'h2);
    rd("R8 done cleared", 4'h0, 32'h0);
    // R6 zero length
    wr(4'hC, 0);
    wr(4'h0, 32'h5);
    rd("R6 zero len done", 4'h0, 32'h6);
    chk("R6 irq", {31'b0, irq}, 1);
    chk("R6 no req", {31'b0, mem_req}, 0);
    wr(4'h0, 32'h6);
    copy(32'h400, 32'h600, 7, 0);
    copy(32'h080, 32'h0C0, 1, 3);
    copy(32'h010, 32'h700, 5, 2);
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule